// File: doc/BRIEF.md
# Transmit Word Prefetcher

This block moves transmit data out of a circular buffer held in a 32-bit wide SRAM and feeds it, one byte at a time, into the byte FIFO that drives a serial shifter. Software fills the buffer and then advances a byte-granular write pointer. The block owns the read pointer and exposes it, so software can see how far transmission has progressed.

The block never works from the live write pointer. It captures a snapshot of it before each word fetch and only unpacks bytes up to that snapshot, so a word that software is still filling is never consumed early. When the read pointer catches up with the snapshot in the middle of a word, the block returns to idle. It takes a fresh snapshot and reads the word again once software moves the pointer on. Software that advances the pointer a whole word at a time therefore costs one SRAM read per four bytes. Byte-wise advances cost one read per byte.

Pointers carry a phase bit above the byte offset, so the block can tell a completely full buffer from an empty one. A soft-reset input returns the read pointer and the holding word to zero. It is meant to be used while the serial side is idle.

Top module: `tx_word_prefetch`

## Requirements
- R1: After rst_n is released, rptr is zero, and sram_req and fifo_push are low while wptr equals zero.
- R2: A pointer holds the byte offset in bits [SRAM_AW+1:0] and a phase bit in bit SRAM_AW+2. The buffer is empty when rptr equals the write-pointer snapshot. When the offsets match but the phases differ, the buffer is full, and all 4*(limit_addr-base_addr) bytes are delivered.
- R3: Each fetch raises sram_req for exactly one cycle, with sram_addr = base_addr + rptr[SRAM_AW+1:2]. The word arrives with sram_rvalid, and bits [8k+7:8k] of sram_rdata hold the byte at offset 4*word+k.
- R4: Bytes are pushed in ascending offset order, one per cycle in which fifo_push is high. rptr advances by one per push and changes at no other time except soft reset.
- R5: When the offset would reach 4*(limit_addr-base_addr), it returns to 0 and the phase bit inverts.
- R6: The block pushes only bytes below a write-pointer snapshot taken before the fetch. If wptr moves past the snapshot after a word was read, the newly covered bytes of that word come from a fresh SRAM read.
- R7: Transfer stops with rptr equal to wptr. Each later advance of wptr within a word already partly sent causes one more read of that word.
- R8: fifo_push is never high while fifo_full is high. A pending byte waits, neither lost nor repeated.
- R9: While soft_rst is high, no push and no fetch take place. One cycle later rptr is zero. The half-sent word is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of read pointer and holding word |
| base_addr | input | SRAM_AW | First SRAM word of the buffer |
| limit_addr | input | SRAM_AW | Word just past the buffer |
| wptr | input | SRAM_AW+3 | Software write pointer, phase bit at the top |
| rptr | output | SRAM_AW+3 | Read pointer, phase bit at the top |
| sram_req | output | 1 | SRAM read request |
| sram_addr | output | SRAM_AW | SRAM word address |
| sram_rvalid | input | 1 | Read data valid |
| sram_rdata | input | 32 | Read data word |
| fifo_full | input | 1 | Byte FIFO cannot accept a byte |
| fifo_push | output | 1 | Byte FIFO push strobe |
| fifo_data | output | 8 | Byte to push |

## Verification
The bench builds the block with SRAM_AW = 6 and places a four-word buffer at words 4 to 7. With this small buffer, 16 bytes are enough to reach the offset wrap with its phase flip and the full-buffer case where the offsets match but the phases differ. The nonzero base checks the address addition. The SRAM model answers one cycle after each request. This leaves a window in which the bench rewrites a word and moves wptr after the word was read, which exposes any use of the live pointer instead of the snapshot.

// File: rtl/tx_word_prefetch.sv
module tx_word_prefetch #(
  parameter int SRAM_AW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst,
  input  logic [SRAM_AW-1:0]   base_addr,
  input  logic [SRAM_AW-1:0]   limit_addr,
  input  logic [SRAM_AW+2:0]   wptr,
  output logic [SRAM_AW+2:0]   rptr,
  output logic                 sram_req,
  output logic [SRAM_AW-1:0]   sram_addr,
  input  logic                 sram_rvalid,
  input  logic [31:0]          sram_rdata,
  input  logic                 fifo_full,
  output logic                 fifo_push,
  output logic [7:0]           fifo_data
);
  localparam int OFF_W = SRAM_AW + 2;
  localparam int PTR_W = OFF_W + 1;

  typedef enum logic [1:0] {IDLE, FETCH, PUSH} state_t;

  state_t             st;
  logic [PTR_W-1:0]   wsnap;
  logic [31:0]        hold;
  logic [OFF_W-1:0]   size_b;
  logic [OFF_W-1:0]   off_inc;
  logic [PTR_W-1:0]   rptr_nx;

  assign size_b  = {limit_addr - base_addr, 2'b00};
  assign off_inc = rptr[OFF_W-1:0] + 1'b1;
  assign rptr_nx = (off_inc == size_b) ? {~rptr[OFF_W], {OFF_W{1'b0}}}
                                       : {rptr[OFF_W], off_inc};

  assign sram_req  = (st == IDLE) && !soft_rst && (rptr != wsnap);
  assign sram_addr = base_addr + rptr[OFF_W-1:2];
  assign fifo_push = (st == PUSH) && !fifo_full && !soft_rst;
  assign fifo_data = hold[8*rptr[1:0] +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      rptr  <= '0;
      wsnap <= '0;
      hold  <= '0;
    end else if (soft_rst) begin
      st    <= IDLE;
      rptr  <= '0;
      wsnap <= '0;
      hold  <= '0;
    end else begin
      case (st)
        IDLE: begin
          wsnap <= wptr;
          if (sram_req) st <= FETCH;
        end
        FETCH: begin
          if (sram_rvalid) begin
            hold <= sram_rdata;
            st   <= PUSH;
          end
        end
        PUSH: begin
          if (fifo_push) begin
            rptr <= rptr_nx;
            if (rptr_nx[1:0] == 2'b00 || rptr_nx == wsnap) st <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module tx_word_prefetch_chk #(
  parameter int SRAM_AW = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               soft_rst,
  input logic [SRAM_AW+2:0] rptr,
  input logic               sram_req,
  input logic               fifo_full,
  input logic               fifo_push
);
  assert_no_push_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> !fifo_full);

  assert_rptr_moves_on_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_push && !soft_rst) |=> $stable(rptr));

  assert_single_cycle_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sram_req |=> !sram_req);

  assert_soft_rst_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (!fifo_push && !sram_req));

  assert_soft_rst_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (rptr == '0));
endmodule

bind tx_word_prefetch tx_word_prefetch_chk #(.SRAM_AW(SRAM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rptr(rptr),
  .sram_req(sram_req), .fifo_full(fifo_full), .fifo_push(fifo_push)
);

// File: tb/tx_word_prefetch_test.sv
module tx_word_prefetch_test;
  localparam int AW = 6;
  localparam int PW = AW + 3;
  localparam logic [AW-1:0] BASE = 6'd4;
  localparam logic [AW-1:0] LIMIT = 6'd8;
  localparam int NVEC = 6;
  // {wptr, expected bytes, expected reads}
  localparam logic [PW-1:0] VW [NVEC] = '{9'h004, 9'h006, 9'h007, 9'h008, 9'h100, 9'h000};
  localparam int VB [NVEC] = '{4, 2, 1, 1, 8, 16};
  localparam int VR [NVEC] = '{1, 1, 1, 1, 2, 4};

  logic clk = 0, rst_n = 0, soft_rst = 0, fifo_full = 0;
  logic [PW-1:0] wptr = '0, rptr;
  logic sram_req, sram_rvalid = 0, fifo_push;
  logic [AW-1:0] sram_addr;
  logic [31:0] sram_rdata = '0;
  logic [7:0] fifo_data;
  logic [31:0] mem [64];
  int checks = 0, errors = 0, pushes = 0, reads = 0;
  logic [PW-1:0] exp_off = '0;
  logic [7:0] exp_b;

  always #10 clk = ~clk;

  tx_word_prefetch #(.SRAM_AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .base_addr(BASE),
    .limit_addr(LIMIT), .wptr(wptr), .rptr(rptr), .sram_req(sram_req),
    .sram_addr(sram_addr), .sram_rvalid(sram_rvalid), .sram_rdata(sram_rdata),
    .fifo_full(fifo_full), .fifo_push(fifo_push), .fifo_data(fifo_data)
  );

  always @(posedge clk) begin
    sram_rvalid <= sram_req;
    sram_rdata  <= mem[sram_addr];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R3/R4/R5/R8 byte monitor with independent offset model (wrap at 16 bytes)
  always @(negedge clk) if (rst_n) begin
    if (sram_req) reads++;
    if (fifo_push) begin
      pushes++;
      exp_b = mem[BASE + exp_off[7:2]][8*exp_off[1:0] +: 8];
      check(fifo_data == exp_b, "R4 byte order", fifo_data, exp_b);
      check(!fifo_full, "R8 push while full", 1, 0);
      if (exp_off[7:0] + 1 == 16) exp_off = {~exp_off[8], 8'h00};
      else exp_off = exp_off + 1;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)} ^ 32'h5A5A5A5A;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(rptr == 0, "R1 rptr", rptr, 0);
    check(pushes == 0 && reads == 0, "R1 idle", pushes + reads, 0);

    for (int v = 0; v < NVEC; v++) begin
      pushes = 0; reads = 0;
      wptr = VW[v];
      repeat (40) @(negedge clk);
      check(rptr == VW[v], (v >= 4) ? "R2 R5 rptr" : "R7 rptr", rptr, VW[v]);
      check(pushes == VB[v], "R2 byte count", pushes, VB[v]);
      check(reads == VR[v], "R3 R7 reads", reads, VR[v]);
    end

    // backpressure
    pushes = 0; reads = 0;
    fifo_full = 1; wptr = 9'h003;
    repeat (20) @(negedge clk);
    check(pushes == 0 && rptr == 0, "R8 held", rptr, 0);
    check(reads == 1, "R8 prefetch", reads, 1);
    fifo_full = 0;
    repeat (20) @(negedge clk);
    check(rptr == 9'h003 && pushes == 3, "R8 release", rptr, 3);

    // soft reset mid-word
    pushes = 0;
    fifo_full = 1; wptr = 9'h008;
    repeat (10) @(negedge clk);
    soft_rst = 1; wptr = '0;
    @(negedge clk);
    soft_rst = 0; fifo_full = 0; exp_off = '0;
    check(rptr == 0, "R9 cleared", rptr, 0);
    repeat (20) @(negedge clk);
    check(pushes == 0 && rptr == 0, "R9 no push", pushes, 0);

    // snapshot: move wptr after the word was read
    pushes = 0; reads = 0;
    wptr = 9'h002;
    while (!sram_rvalid) @(negedge clk);
    mem[BASE] = mem[BASE] ^ 32'hC3C30000;
    wptr = 9'h004;
    repeat (30) @(negedge clk);
    check(rptr == 9'h004 && pushes == 4, "R6 rptr", rptr, 4);
    check(reads == 2, "R6 refetch", reads, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule